// File: doc/BRIEF.md
# Capture/Compare Timer with Sticky Overflow Flag

An up-counter with a set of channel registers. Each channel either captures the running count on a trigger edge or watches the count and pulses when it equals a stored value. The count runs at one step per clock while the external count-enable input is high. While that input is low, the count is held at zero. A mode input picks how the channel roles are assigned and whether a wrap of the counter is reported.

An 8-bit option register sits on a small register bus. It holds one capture/compare selector per channel and a sticky overflow flag. Software can clear the flag but can never set it. Reads do not disturb it. It exists only in the two modes where a wrap is meaningful, and each time it is set it raises a one-cycle interrupt. The selectors only take effect in free-running mode, and they can only be changed while the timer is stopped.

The bus reaches the option register at address 0, channel *i* at address *i*+1 and the counter at address NUM_CH+1. It supports whole-register writes and single-bit writes to the option register. Read data is combinational from the address.

Top module: `tmr_capcmp`

## Requirements
- R1: After a synchronous active-low reset, the option register reads 00H, the counter reads 0, and all pulse outputs are low.
- R2: The option register reads back with bit 4 as the channel 0 selector, bit 5 as the channel 1 selector (0 = compare, 1 = capture) and bit 0 as the overflow flag. Bits 7, 6, 3, 2 and 1 always read 0, even after ones are written to them.
- R3: While `run_en` is 0 the counter is held at 0. While it is 1 the counter adds one per clock from 0. In interval mode (`mode` = 00) the counter returns to 0 on the clock after it equals the channel 0 register.
- R4: In free-running mode (01) and pulse-width mode (10), a wrap from all-ones to zero sets the overflow flag, and `ovf_irq` is high for exactly the one cycle in which the flag becomes 1. In modes 00 and 11 a wrap neither sets the flag nor raises `ovf_irq`.
- R5: Reading the option register while the flag is 1 leaves the flag at 1.
- R6: Writing 0 to bit 0 clears the flag, through either a whole-register write or a single-bit write. Writing 1 to bit 0 changes nothing. Driving `run_en` to 0 clears the flag.
- R7: If a wrap and a write of 0 to the flag occur on the same clock, the flag ends at 1.
- R8: The selectors decide channel roles only in mode 01. In mode 10 both channels capture, and in modes 00 and 11 both channels compare. A trigger on a compare channel leaves its register unchanged.
- R9: While `run_en` is 1, writes to the selector bits are ignored and the stored selectors keep their value. While `run_en` is 0, writes to the selector bits are accepted.
- R10: A single-bit write (`bus_bwe`, bit number `bus_bit`, value `bus_wdata[0]`) changes only the addressed option bit.
- R11: A capture channel copies the counter into its register on the clock where its trigger is high and was low on the previous clock. `cap_event` pulses on the cycle after, and the new value reads back at the channel's address.
- R12: A compare channel pulses `cmp_match` for one cycle on the cycle after the counter equals its register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Count enable; 0 holds the counter at 0 and clears the flag |
| mode | input | 2 | 00 interval, 01 free-running, 10 pulse-width, 11 plain compare |
| bus_we | input | 1 | Whole-register write strobe |
| bus_bwe | input | 1 | Single-bit write strobe (option register only) |
| bus_addr | input | ADDR_W | Register address |
| bus_bit | input | 3 | Bit number for a single-bit write |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |
| cap_trig | input | NUM_CH | Capture trigger per channel |
| cmp_match | output | NUM_CH | Compare-match pulse per channel |
| cap_event | output | NUM_CH | Capture-done pulse per channel |
| ovf_irq | output | 1 | Overflow interrupt pulse |

## Verification
The bench builds the block with CNT_W = 8 and NUM_CH = 2. With an 8-bit counter a wrap happens every 256 clocks, so the bench can reach overflows in every mode several times, including a flag clear written on the exact wrap clock. With two channels, the per-channel selector bits 4 and 5 and every mixed capture/compare arrangement can be exercised, while both the wrap and the interval restart stay short enough to observe cycle by cycle.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the capture/compare timer.
package tmr_pkg;

    // Timer operating modes as driven on the mode input.
    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'b00,
        MODE_FREERUN  = 2'b01,
        MODE_PULSEW   = 2'b10,
        MODE_PLAIN    = 2'b11
    } tmr_mode_e;

    // Option register geometry.
    localparam int OPT_W        = 8;
    localparam int OPT_FLAG_BIT = 0;
    localparam int OPT_SEL_LSB  = 4;

endpackage

// File: rtl/tmr_optreg.sv
// Option register: per-channel capture/compare selectors and the sticky
// overflow flag with its interrupt pulse.
// Assumes NUM_CH <= 4 so the selectors fit in bits OPT_SEL_LSB and up.
module tmr_optreg
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              wr_byte,
    input  logic              wr_bit,
    input  logic [2:0]        bit_sel,
    input  logic              flag_wdata,
    input  logic [NUM_CH-1:0] sel_wdata,
    input  logic              wrap_evt,
    output logic [NUM_CH-1:0] sel_q,
    output logic              ovf_flag,
    output logic              ovf_irq,
    output logic [OPT_W-1:0]  opt_rdata
);

    localparam logic [2:0] FLAG_POS = 3'(OPT_FLAG_BIT);

    logic clr_req;

    // Only a written 0 on the flag position asks for a clear.
    assign clr_req = (wr_byte || (wr_bit && bit_sel == FLAG_POS)) && !flag_wdata;

    // Flag and interrupt: stop clears, wrap sets (beats a clear), write 0 clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            ovf_irq  <= 1'b0;
        end else begin
            ovf_irq <= run_en && wrap_evt;
            if (!run_en)
                ovf_flag <= 1'b0;
            else if (wrap_evt)
                ovf_flag <= 1'b1;
            else if (clr_req)
                ovf_flag <= 1'b0;
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        localparam logic [2:0] POS = 3'(OPT_SEL_LSB + i);
        logic hit;
        logic val;
        logic q;
        assign hit = wr_byte || (wr_bit && bit_sel == POS);
        assign val = wr_byte ? sel_wdata[i] : flag_wdata;
        // Selector bit: accepts writes only while the timer is stopped.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= 1'b0;
            else if (!run_en && hit)
                q <= val;
        end
        assign sel_q[i] = q;
    end

    // Read view: reserved bits stay zero.
    always_comb begin
        opt_rdata = '0;
        opt_rdata[OPT_FLAG_BIT] = ovf_flag;
        for (int i = 0; i < NUM_CH; i++)
            opt_rdata[OPT_SEL_LSB + i] = sel_q[i];
    end

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run_en) |-> $stable(sel_q)); // R9
    AST_FLAG_ONLY_BY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ovf_irq); // R6
    AST_STOP_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !ovf_flag); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && wrap_evt) |=> (ovf_flag && ovf_irq)); // R7
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |=> !ovf_irq); // R4

endmodule

// File: rtl/tmr_counter.sv
// Up-counter: held at zero while stopped, one step per clock while running,
// restarts after matching the restart value in interval mode. Flags a wrap
// only in the modes that report overflow.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  tmr_mode_e        mode,
    input  logic [CNT_W-1:0] restart_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             wrap_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic restart;

    assign restart  = run_en && (mode == MODE_INTERVAL) && (cnt_q == restart_val);
    assign wrap_evt = run_en && (cnt_q == CNT_MAX) &&
                      ((mode == MODE_FREERUN) || (mode == MODE_PULSEW));

    // Count register: zero when stopped or restarting, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en || restart)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CNT_W'(1);
    end

    AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (cnt_q == '0)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run_en) && !$past(restart))
        |-> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R3
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/tmr_channel.sv
// One channel register: captures the count on a trigger rising edge when in
// capture role, otherwise compares against the count and pulses on equality.
// Assumes the trigger is already synchronous to clk.
module tmr_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             cap_role,
    input  logic             trig,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] val_q,
    output logic             match_o,
    output logic             cap_o
);

    logic trig_q;
    logic trig_rise;
    logic do_cap;

    assign trig_rise = trig && !trig_q;
    assign do_cap    = run_en && cap_role && trig_rise;

    // Edge history, event pulses and the channel value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q  <= 1'b0;
            cap_o   <= 1'b0;
            match_o <= 1'b0;
            val_q   <= '0;
        end else begin
            trig_q  <= trig;
            cap_o   <= do_cap;
            match_o <= run_en && !cap_role && (cnt == val_q);
            if (do_cap)
                val_q <= cnt;
            else if (wr_en)
                val_q <= wdata;
        end
    end

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |-> (val_q == $past(cnt))); // R11
    AST_MATCH_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ($past(cnt) == $past(val_q))); // R12
    AST_MATCH_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> !$past(cap_role)); // R8
    AST_ROLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(match_o && cap_o)); // R8

endmodule

// File: rtl/tmr_capcmp.sv
// Capture/compare timer top: counter, option register, and NUM_CH channels
// behind a small register bus. Address 0 = option register, i+1 = channel i,
// NUM_CH+1 = counter. Assumes CNT_W >= 8 and NUM_CH <= 4.
module tmr_capcmp
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = $clog2(NUM_CH + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [1:0]        mode,
    input  logic              bus_we,
    input  logic              bus_bwe,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_bit,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [NUM_CH-1:0] cap_trig,
    output logic [NUM_CH-1:0] cmp_match,
    output logic [NUM_CH-1:0] cap_event,
    output logic              ovf_irq
);

    localparam logic [ADDR_W-1:0] OPT_ADDR = '0;
    localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(NUM_CH + 1);

    tmr_mode_e          mode_e;
    logic [CNT_W-1:0]   cnt_q;
    logic               wrap_evt;
    logic [NUM_CH-1:0]  sel_q;
    logic [NUM_CH-1:0]  cap_role;
    logic               ovf_flag;
    logic [OPT_W-1:0]   opt_rdata;
    logic [CNT_W-1:0]   ch_val [NUM_CH];
    logic               opt_wr_byte;
    logic               opt_wr_bit;

    assign mode_e      = tmr_mode_e'(mode);
    assign opt_wr_byte = bus_we  && (bus_addr == OPT_ADDR);
    assign opt_wr_bit  = bus_bwe && (bus_addr == OPT_ADDR);

    tmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .mode        (mode_e),
        .restart_val (ch_val[0]),
        .cnt_q       (cnt_q),
        .wrap_evt    (wrap_evt)
    );

    tmr_optreg #(.NUM_CH(NUM_CH)) u_optreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .wr_byte    (opt_wr_byte),
        .wr_bit     (opt_wr_bit),
        .bit_sel    (bus_bit),
        .flag_wdata (bus_wdata[OPT_FLAG_BIT]),
        .sel_wdata  (bus_wdata[OPT_SEL_LSB +: NUM_CH]),
        .wrap_evt   (wrap_evt),
        .sel_q      (sel_q),
        .ovf_flag   (ovf_flag),
        .ovf_irq    (ovf_irq),
        .opt_rdata  (opt_rdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic wr_en;
        // Role decode: selectors count only in free-running mode.
        assign cap_role[i] = (mode_e == MODE_FREERUN) ? sel_q[i] : (mode_e == MODE_PULSEW);
        assign wr_en       = bus_we && (bus_addr == ADDR_W'(i + 1));

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_en   (run_en),
            .cap_role (cap_role[i]),
            .trig     (cap_trig[i]),
            .cnt      (cnt_q),
            .wr_en    (wr_en),
            .wdata    (bus_wdata),
            .val_q    (ch_val[i]),
            .match_o  (cmp_match[i]),
            .cap_o    (cap_event[i])
        );
    end

    // Read mux selected by address.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OPT_ADDR)
            bus_rdata[OPT_W-1:0] = opt_rdata;
        else if (bus_addr == CNT_ADDR)
            bus_rdata = cnt_q;
        for (int i = 0; i < NUM_CH; i++)
            if (bus_addr == ADDR_W'(i + 1))
                bus_rdata = ch_val[i];
    end

    AST_NO_IRQ_OUTSIDE_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> ($past(mode_e) == MODE_FREERUN || $past(mode_e) == MODE_PULSEW)); // R4
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_flag) && $past(run_en) && !$past(bus_we) && !$past(bus_bwe))
        |-> ovf_flag); // R5

endmodule

// File: tb/tmr_capcmp_bench.sv
// Self-checking bench with a behavioural cycle model compared on every clock.
module tmr_capcmp_bench;

    localparam int CNT_W  = 8;
    localparam int NUM_CH = 2;
    localparam int ADDR_W = 2;
    localparam int MAXV   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_en = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic              bus_we = 1'b0;
    logic              bus_bwe = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [2:0]        bus_bit = '0;
    logic [CNT_W-1:0]  bus_wdata = '0;
    logic [CNT_W-1:0]  bus_rdata;
    logic [NUM_CH-1:0] cap_trig = '0;
    logic [NUM_CH-1:0] cmp_match;
    logic [NUM_CH-1:0] cap_event;
    logic              ovf_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    int m_cnt = 0, m_ovf = 0, m_irq = 0;
    int m_sel [NUM_CH];
    int m_ch [NUM_CH];
    int m_trigp [NUM_CH];
    int m_match [NUM_CH];
    int m_cap [NUM_CH];

    always #10 clk = ~clk; // 50 MHz

    tmr_capcmp #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_tmr_capcmp (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode(mode),
        .bus_we(bus_we), .bus_bwe(bus_bwe), .bus_addr(bus_addr), .bus_bit(bus_bit),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_trig(cap_trig),
        .cmp_match(cmp_match), .cap_event(cap_event), .ovf_irq(ovf_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_rdata(input int a);
        if (a == 0) return m_ovf | (m_sel[0] << 4) | (m_sel[1] << 5);
        if (a == NUM_CH + 1) return m_cnt;
        return m_ch[a - 1];
    endfunction

    // Model step on each rising edge from the inputs held since the last falling edge.
    always @(posedge clk) begin : mdl
        int md, run, wrap, restart, clr, a, role, rise, ncap, nmatch;
        md  = int'(mode);
        run = int'(run_en);
        a   = int'(bus_addr);
        if (!rst_n) begin
            m_cnt = 0; m_ovf = 0; m_irq = 0;
            for (int i = 0; i < NUM_CH; i++) begin
                m_sel[i] = 0; m_ch[i] = 0; m_trigp[i] = 0; m_match[i] = 0; m_cap[i] = 0;
            end
        end else begin
            wrap    = (run == 1 && m_cnt == MAXV && (md == 1 || md == 2)) ? 1 : 0;
            restart = (run == 1 && md == 0 && m_cnt == m_ch[0]) ? 1 : 0;
            clr     = (a == 0 && int'(bus_wdata[0]) == 0 &&
                       (bus_we || (bus_bwe && int'(bus_bit) == 0))) ? 1 : 0;
            for (int i = 0; i < NUM_CH; i++) begin
                role   = (md == 1) ? m_sel[i] : ((md == 2) ? 1 : 0);
                rise   = (int'(cap_trig[i]) == 1 && m_trigp[i] == 0) ? 1 : 0;
                ncap   = (run == 1 && role == 1 && rise == 1) ? 1 : 0;
                nmatch = (run == 1 && role == 0 && m_cnt == m_ch[i]) ? 1 : 0;
                m_trigp[i] = int'(cap_trig[i]);
                if (ncap == 1) m_ch[i] = m_cnt;
                else if (bus_we && a == i + 1) m_ch[i] = int'(bus_wdata);
                m_cap[i] = ncap;
                m_match[i] = nmatch;
                if (run == 0 && a == 0) begin
                    if (bus_we) m_sel[i] = int'(bus_wdata[4 + i]);
                    if (bus_bwe && int'(bus_bit) == 4 + i) m_sel[i] = int'(bus_wdata[0]);
                end
            end
            if (run == 0) m_ovf = 0;
            else if (wrap == 1) m_ovf = 1;
            else if (clr == 1) m_ovf = 0;
            m_irq = wrap;
            if (run == 0 || restart == 1) m_cnt = 0;
            else m_cnt = (m_cnt + 1) & MAXV;
        end
    end

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int a;
            a = int'(bus_addr);
            check("R12 cmp_match", int'(cmp_match), m_match[0] | (m_match[1] << 1));
            check("R11 cap_event", int'(cap_event), m_cap[0] | (m_cap[1] << 1));
            check("R4 ovf_irq", int'(ovf_irq), m_irq);
            if (a == 0) check("R2 option read", int'(bus_rdata), model_rdata(a));
            else if (a == NUM_CH + 1) check("R3 counter read", int'(bus_rdata), model_rdata(a));
            else check("R11 channel read", int'(bus_rdata), model_rdata(a));
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_word(input int a, input int d);
        bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = CNT_W'(d);
        tick();
        bus_we = 1'b0;
    endtask

    task automatic wr_bit(input int b, input int v);
        bus_bwe = 1'b1; bus_addr = '0; bus_bit = 3'(b); bus_wdata = CNT_W'(v);
        tick();
        bus_bwe = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        bus_addr = ADDR_W'(a);
        #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic pulse(input int ch);
        cap_trig[ch] = 1'b1;
        repeat (3) tick();
        cap_trig[ch] = 1'b0;
        tick();
    endtask

    task automatic wait_irq();
        int g = 0;
        while (m_irq == 0 && g < 1000) begin
            tick();
            g++;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        // R1 reset state
        rd_chk("R1 option after reset", 0, 0);
        rd_chk("R1 counter after reset", 3, 0);
        check("R1 cmp_match", int'(cmp_match), 0);
        check("R1 cap_event", int'(cap_event), 0);
        check("R1 ovf_irq", int'(ovf_irq), 0);
        rst_n = 1'b1;
        tick();

        // R2 R6: all ones written while stopped; reserved stay 0, flag not set
        wr_word(0, 'hFF);
        rd_chk("R2 R6 write FFH", 0, 'h30);
        wr_bit(4, 0);
        rd_chk("R10 bit 4 clear only", 0, 'h20);
        wr_bit(7, 1);
        rd_chk("R2 reserved bit 7", 0, 'h20);
        wr_bit(5, 0);
        wr_bit(4, 1);
        rd_chk("R10 bits 5 and 4", 0, 'h10);

        // Free-running: ch0 capture, ch1 compare at 40H
        wr_word(2, 'h40);
        rd_chk("R12 channel 1 write", 2, 'h40);
        mode = 2'b01;
        run_en = 1'b1;
        bus_addr = 2'd3;
        repeat (20) tick();
        pulse(0);
        rd_chk("R11 captured value", 1, m_ch[0]);
        wr_word(0, 'h20);
        rd_chk("R9 selector write ignored while running", 0, 'h10);
        bus_addr = 2'd3;
        wait_irq();
        rd_chk("R4 flag set on wrap", 0, 'h11);
        repeat (3) begin
            tick();
            rd_chk("R5 flag survives read", 0, 'h11);
        end
        wr_word(0, 'h11);
        rd_chk("R6 R9 same value write", 0, 'h11);
        wr_bit(0, 1);
        rd_chk("R6 write 1 no effect", 0, 'h11);
        wr_bit(0, 0);
        rd_chk("R6 write 0 clears", 0, 'h10);
        bus_addr = 2'd3;
        begin
            int g = 0;
            while (m_cnt != MAXV && g < 1000) begin
                tick();
                g++;
            end
        end
        wr_bit(0, 0);
        rd_chk("R7 wrap beats clear", 0, 'h11);

        // Stop: flag cleared, counter held, selectors writable
        run_en = 1'b0;
        repeat (2) tick();
        rd_chk("R6 stop clears flag", 0, 'h10);
        rd_chk("R3 stopped counter", 3, 0);
        wr_word(0, 'h20);
        rd_chk("R9 selector write accepted while stopped", 0, 'h20);

        // Pulse-width: both channels capture regardless of selectors
        mode = 2'b10;
        run_en = 1'b1;
        bus_addr = 2'd1;
        repeat (10) tick();
        pulse(0);
        repeat (15) tick();
        pulse(1);
        rd_chk("R8 channel 1 captures in pulse-width", 2, m_ch[1]);
        wait_irq();
        rd_chk("R4 flag in pulse-width", 0, 'h21);

        // Interval: restart after channel 0, triggers ignored
        run_en = 1'b0;
        tick();
        mode = 2'b00;
        wr_word(1, 'h10);
        wr_word(2, 'h08);
        run_en = 1'b1;
        bus_addr = 2'd3;
        repeat (40) tick();
        pulse(0);
        rd_chk("R8 compare channel ignores trigger", 1, 'h10);
        bus_addr = 2'd3;
        repeat (300) tick();
        rd_chk("R4 no flag in interval mode", 0, 'h20);

        // Plain compare: wraps without flag or interrupt
        run_en = 1'b0;
        tick();
        mode = 2'b11;
        run_en = 1'b1;
        bus_addr = 2'd3;
        repeat (600) tick();
        rd_chk("R4 no flag in plain mode", 0, 'h20);
        run_en = 1'b0;
        repeat (2) tick();

        finish_run();
    end

endmodule